// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is a byte-oriented I2C target. It samples SCL and SDA on the system clock and finds start, repeated start and stop conditions. It compares the first byte of every transfer with a programmable 7-bit address, and it accepts the all-zero general-call byte as well. Bytes written by the bus controller go into a receive ring buffer. Bytes the controller reads come from a transmit ring buffer that the host fills. The host drains and fills the buffers through valid/ready byte ports and can watch their fill levels. Both pads are open-drain: the block only asserts output enables, and each enable pulls its line low.

Bit framing uses a 4-bit edge counter that advances on both edges of SCL. It is preset to 0 for an eight-bit byte (16 edges) and to 14 for a single acknowledge bit (2 edges). When the counter wraps, the protocol state machine decides the next step. During that decision, and after the first SCL fall that follows a start, the block holds SCL low for a fixed number of system cycles. A controller that waits for SCL to rise therefore sees the stretch.

A repeated start restarts address checking at any point. A stop returns the block to idle from any state.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, neither line is pulled low, rx_valid is 0, tx_ready is 1 and both fill levels are 0.
- R2: The block ACKs an address byte whose upper seven bits equal own_addr by driving SDA low during the ninth clock. Bit 0 of that byte selects a read (1) or a write (0).
- R3: The block ACKs the address byte 0x00 (general call) and treats it as a write.
- R4: Any other address byte gets no ACK. All following bytes are ignored until the next start, and rx_level stays 0.
- R5: In a write, the block ACKs each data byte and pushes it into the receive buffer. The host receives the bytes in arrival order.
- R6: If a byte arrives while the receive buffer holds FIFO_DEPTH-1 entries, the block still ACKs it but discards it. The stored bytes and the level do not change.
- R7: In a read, the block sends the transmit-buffer bytes MSB first. It changes SDA only while SCL is low, and it takes each next byte in push order after the controller ACKs.
- R8: A NACK from the controller ends a read. SDA is released and no further byte is taken from the transmit buffer.
- R9: If the transmit buffer is empty when a byte is due, the block releases SDA and goes idle, so the controller reads 0xFF.
- R10: The block pulls SCL low for exactly STRETCH_CYC system cycles after every counter wrap and after the first SCL fall that follows a start. An address-plus-two-bytes write produces 7 such pulses.
- R11: A repeated start in the middle of a transfer restarts address checking. A following read of the block is served normally.
- R12: A stop, even one in the middle of a byte, releases both lines and returns the block to idle. A later transfer then works normally.
- R13: Each fill level equals head minus tail modulo FIFO_DEPTH. The buffer holds at most FIFO_DEPTH-1 bytes, and tx_ready is 0 when the transmit buffer is at that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Programmed target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive buffer not empty |
| rx_ready | input | 1 | Host takes rx_data |
| rx_level | output | $clog2(FIFO_DEPTH) | Receive fill level |
| tx_data | input | 8 | Byte offered for reads |
| tx_valid | input | 1 | Host offers tx_data |
| tx_ready | output | 1 | Transmit buffer has space |
| tx_level | output | $clog2(FIFO_DEPTH) | Transmit fill level |

## Verification
The two-stage synchroniser puts bus decisions 2 to 3 system cycles behind a line change. The stretch pulse begins on the cycle after the synchronised SCL fall, and SDA changes within about 4 cycles of an SCL fall. The bench therefore samples SDA halfway through each SCL high phase, which is at least 4 cycles after the rise it has waited for. Buffer handshakes take effect on the next clock edge. The bench drives inputs on falling clock edges and reads the fill levels and rx_data on a later falling edge, after each transfer has ended. A monitor measures every SCL hold pulse, counting cycles at falling edges.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int EDGE_W = 4;

    typedef enum logic [2:0] {
        P_CHK_ADDR  = 3'd0,
        P_SEND      = 3'd1,
        P_REQ_REPLY = 3'd2,
        P_CHK_REPLY = 3'd3,
        P_REQ_DATA  = 3'd4,
        P_GET_DATA  = 3'd5
    } proto_e;

    typedef enum logic [1:0] {
        L_IDLE   = 2'd0,
        L_START  = 2'd1,
        L_ACTIVE = 2'd2
    } link_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_chain;
        logic [STAGES-1:0] sda_chain;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.scl_chain[0] = scl_i;
        d.sda_chain[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            d.scl_chain[i] = q.scl_chain[i-1];
            d.sda_chain[i] = q.sda_chain[i-1];
        end
        d.scl_prev = q.scl_chain[STAGES-1];
        d.sda_prev = q.sda_chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o      = q.scl_chain[STAGES-1];
    assign sda_o      = q.sda_chain[STAGES-1];
    assign scl_rise_o = scl_o & ~q.scl_prev;
    assign scl_fall_o = ~scl_o & q.scl_prev;
    assign start_o    = scl_o & q.scl_prev & q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & q.scl_prev & ~q.sda_prev & sda_o;

endmodule

// File: rtl/i2c_byte_ring.sv
module i2c_byte_ring #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic [WIDTH-1:0]         push_data_i,
    input  logic                     pop_i,
    output logic [WIDTH-1:0]         head_data_o,
    output logic                     empty_o,
    output logic                     full_o,
    output logic [$clog2(DEPTH)-1:0] level_o
);

    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty_o = (q.head == q.tail);
    assign full_o  = ((q.head + PW'(1)) == q.tail);
    assign level_o = q.head - q.tail;
    assign head_data_o = mem_q[q.tail];
    assign push_ok = push_i & ~full_o;
    assign pop_ok  = pop_i & ~empty_o;

    always_comb begin
        d = q;
        if (push_ok) d.head = q.head + PW'(1);
        if (pop_ok)  d.tail = q.tail + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[q.head] <= push_data_i;
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> $stable(level_o)); // R6
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> (level_o == '0)); // R13
    AST_PUSH_STEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !pop_i) |=> (level_o == $past(level_o) + PW'(1))); // R13

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl #(
    parameter int FIFO_DEPTH  = 4,
    parameter int STRETCH_CYC = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [6:0]                    own_addr,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          scl_oe,
    output logic                          sda_oe,
    output logic [7:0]                    rx_data,
    output logic                          rx_valid,
    input  logic                          rx_ready,
    output logic [$clog2(FIFO_DEPTH)-1:0] rx_level,
    input  logic [7:0]                    tx_data,
    input  logic                          tx_valid,
    output logic                          tx_ready,
    output logic [$clog2(FIFO_DEPTH)-1:0] tx_level
);
    import i2c_tgt_pkg::*;

    localparam int HOLD_W = $clog2(STRETCH_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(STRETCH_CYC);
    localparam logic [EDGE_W-1:0] CNT_LAST  = '1;
    localparam logic [EDGE_W-1:0] CNT_ACK   = CNT_LAST - EDGE_W'(1);

    typedef struct packed {
        link_e              link;
        proto_e             proto;
        logic [EDGE_W-1:0]  cnt;
        logic [BYTE_W-1:0]  shreg;
        logic               out_bit;
        logic               drive;
        logic [HOLD_W-1:0]  hold;
    } ctl_t;

    ctl_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic rx_push, rx_empty, rx_full;
    logic tx_pop, tx_empty, tx_full;
    logic [7:0] tx_head;
    logic addr_hit, load_next;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    i2c_byte_ring #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) rx_ring_i (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .push_data_i(q.shreg),
        .pop_i(rx_ready), .head_data_o(rx_data), .empty_o(rx_empty),
        .full_o(rx_full), .level_o(rx_level)
    );

    i2c_byte_ring #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) tx_ring_i (
        .clk(clk), .rst_n(rst_n), .push_i(tx_valid), .push_data_i(tx_data),
        .pop_i(tx_pop), .head_data_o(tx_head), .empty_o(tx_empty),
        .full_o(tx_full), .level_o(tx_level)
    );

    assign rx_valid  = ~rx_empty;
    assign tx_ready  = ~tx_full;
    assign addr_hit  = (q.shreg == '0) || (q.shreg[7:1] == own_addr);
    assign load_next = (q.proto == P_SEND) ||
                       ((q.proto == P_CHK_REPLY) && (q.shreg == '0));

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        if (q.hold != '0) d.hold = q.hold - HOLD_W'(1);
        if (start_det) begin
            d.link    = L_START;
            d.drive   = 1'b0;
            d.out_bit = 1'b1;
        end else if (stop_det) begin
            d.link    = L_IDLE;
            d.drive   = 1'b0;
            d.out_bit = 1'b1;
        end else begin
            unique case (q.link)
                L_START: begin
                    if (scl_fall) begin
                        d.link    = L_ACTIVE;
                        d.proto   = P_CHK_ADDR;
                        d.cnt     = '0;
                        d.shreg   = '0;
                        d.drive   = 1'b0;
                        d.out_bit = 1'b1;
                        d.hold    = HOLD_INIT;
                    end
                end
                L_ACTIVE: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + EDGE_W'(1);
                    end else if (scl_fall && (q.cnt != CNT_LAST)) begin
                        d.cnt     = q.cnt + EDGE_W'(1);
                        d.out_bit = q.shreg[BYTE_W-1];
                    end else if (scl_fall) begin
                        d.hold = HOLD_INIT;
                        unique case (q.proto)
                            P_CHK_ADDR: begin
                                if (addr_hit) begin
                                    d.proto   = q.shreg[0] ? P_SEND : P_REQ_DATA;
                                    d.shreg   = '0;
                                    d.out_bit = 1'b0;
                                    d.drive   = 1'b1;
                                    d.cnt     = CNT_ACK;
                                end else begin
                                    d.link    = L_IDLE;
                                    d.drive   = 1'b0;
                                    d.out_bit = 1'b1;
                                end
                            end
                            P_SEND, P_CHK_REPLY: begin
                                if (load_next && !tx_empty) begin
                                    tx_pop    = 1'b1;
                                    d.shreg   = tx_head;
                                    d.out_bit = tx_head[BYTE_W-1];
                                    d.drive   = 1'b1;
                                    d.cnt     = '0;
                                    d.proto   = P_REQ_REPLY;
                                end else begin
                                    d.link    = L_IDLE;
                                    d.drive   = 1'b0;
                                    d.out_bit = 1'b1;
                                end
                            end
                            P_REQ_REPLY: begin
                                d.proto   = P_CHK_REPLY;
                                d.drive   = 1'b0;
                                d.out_bit = 1'b1;
                                d.shreg   = '0;
                                d.cnt     = CNT_ACK;
                            end
                            P_REQ_DATA: begin
                                d.proto   = P_GET_DATA;
                                d.drive   = 1'b0;
                                d.out_bit = 1'b1;
                                d.cnt     = '0;
                            end
                            P_GET_DATA: begin
                                rx_push   = ~rx_full;
                                d.proto   = P_REQ_DATA;
                                d.shreg   = '0;
                                d.out_bit = 1'b0;
                                d.drive   = 1'b1;
                                d.cnt     = CNT_ACK;
                            end
                            default: begin
                                d.link  = L_IDLE;
                                d.drive = 1'b0;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.link    <= L_IDLE;
            q.proto   <= P_CHK_ADDR;
            q.out_bit <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_oe = (q.hold != '0);
    assign sda_oe = q.drive & ~q.out_bit;

    logic [HOLD_W:0] hold_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_run_q <= '0;
        else if (scl_oe) hold_run_q <= hold_run_q + 1'b1;
        else             hold_run_q <= '0;
    end

    AST_STRETCH_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (hold_run_q < (HOLD_W+1)'(STRETCH_CYC))); // R10
    AST_STRETCH_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && (hold_run_q != '0)) |-> (hold_run_q == (HOLD_W+1)'(STRETCH_CYC))); // R10
    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R7
    AST_IDLE_NO_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (q.link == L_IDLE) |-> !sda_oe); // R12
    AST_POP_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (scl_fall && q.cnt == CNT_LAST)); // R8

endmodule

// File: tb/i2c_target_ctrl_tb.sv
module i2c_target_ctrl_tb_top;

    localparam int DEPTH   = 4;
    localparam int STRETCH = 6;
    localparam int HALF    = 8;
    localparam int QTR     = 4;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, scl_bus, sda_bus;
    logic [7:0] rx_data, tx_data = 8'h00;
    logic rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
    logic [1:0] rx_level, tx_level;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_target_ctrl #(.FIFO_DEPTH(DEPTH), .STRETCH_CYC(STRETCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_level(rx_level), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_level(tx_level)
    );

    int checks = 0, errors = 0, pulses = 0, run = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R10: every hold pulse lasts STRETCH cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_oe) run++;
            else if (run != 0) begin
                check(run == STRETCH, "R10 pulse length", run, STRETCH);
                pulses++;
                run = 0;
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_n(HALF); m_sda = 1'b0; wait_n(HALF); m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_n(QTR); m_sda = 1'b1; wait_n(HALF - QTR);
        scl_up(); wait_n(QTR); m_sda = 1'b0; wait_n(HALF - QTR); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(QTR); m_sda = 1'b0; wait_n(HALF - QTR);
        scl_up(); wait_n(QTR); m_sda = 1'b1; wait_n(HALF);
    endtask

    task automatic put_bit(input logic b);
        wait_n(QTR); m_sda = b; wait_n(HALF - QTR);
        scl_up(); wait_n(HALF); m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wait_n(QTR); m_sda = 1'b1; wait_n(HALF - QTR);
        scl_up(); wait_n(HALF / 2); b = sda_bus; wait_n(HALF - HALF / 2); m_scl = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic give_ack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    task automatic host_push(input logic [7:0] v);
        @(negedge clk); tx_valid = 1'b1; tx_data = v;
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic host_take(input logic [7:0] exp, input string req);
        @(negedge clk);
        check(rx_valid == 1'b1, req, rx_valid, 1);
        check(rx_data == exp, req, rx_data, exp);
        rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all R): actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        wait_n(4); rst_n = 1'b1; wait_n(2);
        // R1 reset state
        check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
        check(!rx_valid && tx_ready, "R1 handshake", {rx_valid, tx_ready}, 1);
        check(rx_level == 0 && tx_level == 0, "R1 levels", {rx_level, tx_level}, 0);

        // R2 R3 R4 address sweep over every 7-bit value, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start();
            write_byte({a[6:0], 1'b0}, ack);
            check(ack == (a == OWN || a == 0), "R2/R3/R4 sweep ack", ack, (a == OWN || a == 0));
            bus_stop();
        end
        check(rx_level == 0, "R4 sweep no data", rx_level, 0);

        // R4 foreign address: data ignored
        bus_start(); write_byte({7'h15, 1'b0}, ack); write_byte(8'h77, ack);
        check(ack == 1'b0, "R4 data not acked", ack, 0);
        bus_stop(); wait_n(4);
        check(rx_level == 0, "R4 level", rx_level, 0);

        // R5 R10 write two bytes
        pulses = 0;
        bus_start(); write_byte({OWN, 1'b0}, ack);
        write_byte(8'h11, ack); check(ack, "R5 ack byte1", ack, 1);
        write_byte(8'h22, ack); check(ack, "R5 ack byte2", ack, 1);
        bus_stop(); wait_n(4);
        check(pulses == 7, "R10 pulse count", pulses, 7);
        check(rx_level == 2, "R5 level", rx_level, 2);
        host_take(8'h11, "R5 order1"); host_take(8'h22, "R5 order2");

        // R3 general call write
        bus_start(); write_byte(8'h00, ack); write_byte(8'h3C, ack);
        check(ack, "R3 data ack", ack, 1);
        bus_stop(); wait_n(4);
        host_take(8'h3C, "R3 data");

        // R6 overflow
        bus_start(); write_byte({OWN, 1'b0}, ack);
        for (int i = 0; i < 4; i++) begin
            write_byte(8'hA0 + 8'(i), ack);
            check(ack, "R6 ack", ack, 1);
        end
        bus_stop(); wait_n(4);
        check(rx_level == DEPTH - 1, "R6 level", rx_level, DEPTH - 1);
        for (int i = 0; i < 3; i++) host_take(8'hA0 + 8'(i), "R6 kept");
        @(negedge clk); check(!rx_valid, "R6 dropped", rx_valid, 0);

        // R13 tx capacity
        host_push(8'h5A); host_push(8'hC3); host_push(8'h81); host_push(8'hEE);
        @(negedge clk);
        check(!tx_ready, "R13 tx_ready", tx_ready, 0);
        check(tx_level == DEPTH - 1, "R13 tx_level", tx_level, DEPTH - 1);

        // R7 R8 read one byte then NACK
        bus_start(); write_byte({OWN, 1'b1}, ack);
        check(ack, "R2 read addr ack", ack, 1);
        read_byte(v, 1'b0);
        check(v == 8'h5A, "R7 first byte", v, 8'h5A);
        bus_stop(); wait_n(4);
        check(tx_level == 2, "R8 no extra pop", tx_level, 2);
        check(!sda_oe, "R8 released", sda_oe, 0);

        // R7 R9 read two with ACK, third from empty buffer
        bus_start(); write_byte({OWN, 1'b1}, ack);
        read_byte(v, 1'b1); check(v == 8'hC3, "R7 second", v, 8'hC3);
        read_byte(v, 1'b1); check(v == 8'h81, "R7 third", v, 8'h81);
        read_byte(v, 1'b0); check(v == 8'hFF, "R9 empty reads FF", v, 8'hFF);
        bus_stop(); wait_n(4);
        check(tx_level == 0, "R9 level", tx_level, 0);

        // R11 repeated start
        host_push(8'h96);
        bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h4D, ack);
        bus_rstart(); write_byte({OWN, 1'b1}, ack);
        check(ack, "R11 addr after restart", ack, 1);
        read_byte(v, 1'b0); check(v == 8'h96, "R11 read", v, 8'h96);
        bus_stop(); wait_n(4);
        host_take(8'h4D, "R11 write part");

        // R12 stop mid address
        bus_start(); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop(); wait_n(4);
        check(!sda_oe && !scl_oe, "R12 released", {scl_oe, sda_oe}, 0);
        bus_start(); write_byte({OWN, 1'b0}, ack); write_byte(8'h6E, ack);
        check(ack, "R12 later ack", ack, 1);
        bus_stop(); wait_n(4);
        host_take(8'h6E, "R12 later data");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule